// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits ahead of the transfer engine of a single DMA channel. It collects the reasons to move data: a hardware request line, which is synchronized and edge-detected, and a CPU transfer strobe. It also collects a CPU strobe that asks for the chain to be terminated. Each of these is recorded as a pending flag. The flags are kept even while the channel is disabled, the way an interrupt controller keeps a flag whose line is masked.

Arbitration runs only while the channel enable bit is set. A pending terminate always wins. When it is serviced, both pending flags are wiped, the enable bit is cleared and a one-cycle terminated pulse is produced. If no terminate is pending, a pending transfer produces a one-cycle start pulse to the engine, and the channel is then busy until the engine returns done.

Software can therefore queue a terminate before it enables the channel. This discards a stale request that was captured while the channel was off. Software then sets enable a second time to start normal operation.

Top module: `dma_req_front`

## Requirements
- R1: A transfer request that arrives while `chan_en` is 0 sets `xfer_pend` on the next clock edge and is not discarded.
- R2: With `chan_en` at 1, the channel not busy, `xfer_pend` at 1 and `term_pend` at 0, `xfer_start` is high for exactly one cycle, on the edge after the one that showed that state. On the same edge `busy` becomes 1 and `xfer_pend` becomes 0.
- R3: A `cpu_term_req` strobe that arrives while the channel is disabled sets `term_pend`, and the flag stays set until a terminate is serviced.
- R4: When a terminate and a transfer are both pending as the channel becomes enabled, the terminate is serviced and no `xfer_start` pulse occurs.
- R5: Servicing a terminate raises `term_pulse` for one cycle. On that same edge it clears `xfer_pend`, `term_pend` and `chan_en`.
- R6: After a terminate, the channel starts no transfer until `en_set` is strobed again. Once it is re-enabled, a new request produces a normal start.
- R7: `drq_in` passes through a two-flop synchronizer and is edge-detected. Holding it high produces a single request, and a new low-to-high transition produces another.
- R8: `xfer_pend` is one bit. Several requests that arrive while it is set cause a single transfer.
- R9: A request that arrives while `busy` is 1 stays pending. It is started on the edge where `xfer_done` is seen, provided the channel is still enabled.
- R10: A terminate that is requested while `busy` is 1 has no effect until `xfer_done` is seen. It is serviced on that edge and clears `busy`.
- R11: Reset clears `chan_en`, `xfer_pend`, `term_pend`, `busy`, `xfer_start` and `term_pulse`.
- R12: When `en_set` and `en_clr` are strobed in the same cycle, `en_clr` wins and `chan_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_set | input | 1 | One-cycle strobe that sets the channel enable bit |
| en_clr | input | 1 | One-cycle strobe that clears the channel enable bit |
| drq_in | input | 1 | Asynchronous hardware transfer request (level) |
| cpu_xfer_req | input | 1 | One-cycle CPU transfer request |
| cpu_term_req | input | 1 | One-cycle CPU terminate-chain request |
| xfer_done | input | 1 | Transfer engine reports that the current transfer has completed |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| term_pulse | output | 1 | One-cycle pulse: a terminate was serviced |
| chan_en | output | 1 | Channel enable bit |
| xfer_pend | output | 1 | Transfer request pending |
| term_pend | output | 1 | Terminate request pending |
| busy | output | 1 | A started transfer has not yet reported done |

## Verification
The functions that can collide are the transfer start and the terminate. Both are judged from the same pending flags on the same edge: the edge where the channel becomes enabled, or the edge where a busy transfer reports done. The bench provokes the clash in two ways. It queues a transfer and a terminate together while the channel is off and then enables it. It also requests a terminate in the middle of a transfer and then returns done. In both cases it checks that only the terminated pulse appears, that the enable bit and both flags drop together, and that the start counter does not move.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef struct packed {
        logic en;      // channel enable bit
        logic xpend;   // transfer request pending
        logic tpend;   // terminate request pending
        logic busy;    // transfer issued, done not yet seen
        logic start;   // one-cycle start pulse
        logic term;    // one-cycle terminated pulse
    } chan_state_t;

    localparam chan_state_t CHAN_RESET = '0;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_d, sync_q;
    logic          prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[LAST-1:0], async_in};
        prev_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_out = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dma_req_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_set,
    input  logic        en_clr,
    input  logic        hw_req,
    input  logic        sw_req,
    input  logic        sw_term,
    input  logic        done,
    output chan_state_t state
);
    chan_state_t s_d, s_q;
    logic        new_req;
    logic        can_decide;

    always_comb begin
        new_req    = hw_req | sw_req;
        can_decide = s_q.en & (~s_q.busy | done);

        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.term  = 1'b0;
        s_d.xpend = s_q.xpend | new_req;
        s_d.tpend = s_q.tpend | sw_term;
        s_d.en    = (s_q.en | en_set) & ~en_clr;

        if (s_q.busy && done) begin
            s_d.busy = 1'b0;
        end

        if (can_decide) begin
            if (s_q.tpend) begin
                // terminate wins: wipe everything and drop enable
                s_d.xpend = 1'b0;
                s_d.tpend = 1'b0;
                s_d.en    = 1'b0;
                s_d.term  = 1'b1;
                s_d.busy  = 1'b0;
            end else if (s_q.xpend) begin
                s_d.start = 1'b1;
                s_d.busy  = 1'b1;
                s_d.xpend = new_req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CHAN_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q;

endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
    import dma_req_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic drq_in,
    input  logic cpu_xfer_req,
    input  logic cpu_term_req,
    input  logic xfer_done,
    output logic xfer_start,
    output logic term_pulse,
    output logic chan_en,
    output logic xfer_pend,
    output logic term_pend,
    output logic busy
);
    logic        drq_rise;
    chan_state_t st;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (drq_in),
        .rise_out (drq_rise)
    );

    dma_req_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .hw_req  (drq_rise),
        .sw_req  (cpu_xfer_req),
        .sw_term (cpu_term_req),
        .done    (xfer_done),
        .state   (st)
    );

    assign xfer_start = st.start;
    assign term_pulse = st.term;
    assign chan_en    = st.en;
    assign xfer_pend  = st.xpend;
    assign term_pend  = st.tpend;
    assign busy       = st.busy;

endmodule

// File: rtl/dma_req_front_chk.sv
module dma_req_front_chk (
    input logic clk,
    input logic rst_n,
    input logic en_set,
    input logic en_clr,
    input logic xfer_done,
    input logic xfer_start,
    input logic term_pulse,
    input logic chan_en,
    input logic xfer_pend,
    input logic term_pend,
    input logic busy
);
    // R5
    term_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |-> (!chan_en && !xfer_pend && !term_pend));

    // R4
    start_term_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, term_pulse}));

    // R2
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ($past(chan_en) && busy));

    // R9
    start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ($past(!busy) || $past(xfer_done)));

    // R10
    term_waits_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> !term_pulse);

    // R12
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !chan_en);

endmodule

bind dma_req_front dma_req_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .xfer_done  (xfer_done),
    .xfer_start (xfer_start),
    .term_pulse (term_pulse),
    .chan_en    (chan_en),
    .xfer_pend  (xfer_pend),
    .term_pend  (term_pend),
    .busy       (busy)
);

// File: tb/dma_req_front_tb.sv
`timescale 1ns/1ps
module dma_req_front_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_set = 0, en_clr = 0, drq_in = 0, cpu_xfer_req = 0, cpu_term_req = 0, xfer_done = 0;
    logic xfer_start, term_pulse, chan_en, xfer_pend, term_pend, busy;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int n_term = 0;

    always #2 clk = ~clk;

    dma_req_front u_dut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .drq_in(drq_in),
        .cpu_xfer_req(cpu_xfer_req), .cpu_term_req(cpu_term_req), .xfer_done(xfer_done),
        .xfer_start(xfer_start), .term_pulse(term_pulse), .chan_en(chan_en),
        .xfer_pend(xfer_pend), .term_pend(term_pend), .busy(busy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_start) n_start++;
            if (term_pulse) n_term++;
        end
    end

    // stimulus [10:6] = {en_set, en_clr, cpu_xfer_req, cpu_term_req, xfer_done}
    // expected [5:0]  = {chan_en, xfer_pend, term_pend, busy, xfer_start, term_pulse}
    localparam logic [10:0] VEC [22] = '{
        11'b00100_010000,  // 0  R1 request held while disabled
        11'b00000_010000,  // 1  R1
        11'b10000_110000,  // 2  R2 enable
        11'b00000_100110,  // 3  R2 start
        11'b00100_110100,  // 4  R9 request while busy
        11'b00100_110100,  // 5  R8 merged
        11'b00001_100110,  // 6  R9 served on done
        11'b00001_100000,  // 7  R8 single transfer
        11'b00010_101000,  // 8  R3
        11'b00000_000001,  // 9  R5 terminate
        11'b00110_011000,  // 10 R3 both held while disabled
        11'b10000_111000,  // 11 R4
        11'b00000_000001,  // 12 R4 terminate wins
        11'b10000_100000,  // 13 R6 re-enable
        11'b00100_110000,  // 14 R6
        11'b00000_100110,  // 15 R6 normal start
        11'b00010_101100,  // 16 R10
        11'b00000_101100,  // 17 R10 waits
        11'b00001_000001,  // 18 R10 serviced on done
        11'b11000_000000,  // 19 R12 clear wins
        11'b10000_100000,  // 20 R12
        11'b01000_000000   // 21 R12
    };

    string tags [22] = '{"R1","R1","R2","R2","R9","R8","R9","R8","R3","R5","R3",
                         "R4","R4","R6","R6","R6","R10","R10","R10","R12","R12","R12"};

    function automatic logic [5:0] outs();
        return {chan_en, xfer_pend, term_pend, busy, xfer_start, term_pulse};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0, t0;
        repeat (3) @(negedge clk);
        check("R11", "outputs after reset", int'(outs()), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            {en_set, en_clr, cpu_xfer_req, cpu_term_req, xfer_done} = VEC[i][10:6];
            @(posedge clk);
            #1;
            check(tags[i], $sformatf("vector %0d outputs", i), int'(outs()), int'(VEC[i][5:0]));
        end
        @(negedge clk);
        {en_set, en_clr, cpu_xfer_req, cpu_term_req, xfer_done} = '0;

        // R7: held DRQ level yields one transfer, a new edge yields another
        xfer_done = 1'b1;
        drq_in = 1'b1;
        wait_cycles(5);
        check("R1", "drq captured while disabled", int'(xfer_pend), 1);
        s0 = n_start;
        pulse(en_set);
        wait_cycles(20);
        check("R7", "starts for held drq", n_start - s0, 1);
        drq_in = 1'b0;
        wait_cycles(5);
        drq_in = 1'b1;
        wait_cycles(20);
        check("R7", "starts after second edge", n_start - s0, 2);

        // Stale drq wiped by queued terminate
        pulse(en_clr);
        drq_in = 1'b0;
        wait_cycles(4);
        drq_in = 1'b1;
        wait_cycles(5);
        drq_in = 1'b0;
        check("R1", "stale drq pending", int'(xfer_pend), 1);
        pulse(cpu_term_req);
        check("R3", "terminate pending", int'(term_pend), 1);
        s0 = n_start;
        t0 = n_term;
        pulse(en_set);
        wait_cycles(5);
        check("R4", "no start with terminate", n_start - s0, 0);
        check("R5", "terminate pulses", n_term - t0, 1);
        check("R5", "enable dropped", int'(chan_en), 0);
        check("R5", "pending cleared", int'(xfer_pend), 0);
        pulse(cpu_xfer_req);
        wait_cycles(3);
        check("R6", "no start before re-enable", n_start - s0, 0);
        pulse(en_set);
        wait_cycles(5);
        check("R6", "queued request served after re-enable", n_start - s0, 1);
        pulse(cpu_xfer_req);
        wait_cycles(5);
        check("R6", "new request served", n_start - s0, 2);

        // R11: reset mid-run with state pending
        pulse(en_clr);
        pulse(cpu_xfer_req);
        pulse(cpu_term_req);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R11", "outputs after mid-run reset", int'(outs()), 0);
        rst_n = 1'b1;
        wait_cycles(2);
        check("R11", "state stays clear", int'(outs()), 0);

        finish_run();
    end

endmodule